// File: doc/BRIEF.md
# Destination Address Receive Filter

This block decides whether a received frame should be kept, using only the 48-bit destination address at the front of the frame. The address arrives one byte per cycle on a byte stream. The first byte is marked by a start-of-frame strobe. Four receive configuration bits select which acceptance rules are active:

- pass everything;
- exact match against the station address;
- hash-based multicast;
- the all-ones broadcast address.

For the multicast rule, a CRC-32 is computed over the six address bytes. The top six bits of the result select one bit of a 64-bit hash table. Software loads that table as two 32-bit words.

One cycle after the sixth address byte, the block raises a decision-valid output. With it come the accept verdict and one flag for each rule that passed. These outputs hold until the next frame starts. Bytes after the sixth are ignored. Bytes that arrive before any start-of-frame are also ignored.

Top module: `rx_dst_filter`

## Requirements
- R1: After reset, dec_valid, accept and all four hit flags are 0.
- R2: The hash index is bits 31:26 of a CRC-32 computed as follows. The register starts at 0xFFFFFFFF. Each address byte is taken in arrival order, bit 0 first. For each bit, the feedback is crc[31] XOR the data bit; the register shifts left by one and, when the feedback is 1, is XORed with 0x04C11DB7. No final inversion is applied. When rx_cfg[2] is 1, the address is multicast and the table bit at that index is 1, hit_mcast and accept are 1.
- R3: A write with hash_wr=1 and hash_sel=0 loads hash_wdata into table bits 31:0. With hash_sel=1 it loads table bits 63:32.
- R4: When rx_cfg[0] is 1, hit_all and accept are 1 for every address.
- R5: When rx_cfg[1] is 1 and the address equals station_addr, hit_phys and accept are 1. The first received byte is compared with station_addr[7:0], and the sixth with station_addr[47:40].
- R6: When rx_cfg[3] is 1 and all 48 address bits are 1, hit_bcast and accept are 1.
- R7: A multicast address has bit 0 of its first byte set. The broadcast address never sets hit_mcast, even when its table bit is 1.
- R8: A rule whose configuration bit is 0 leaves its flag at 0. accept is 1 exactly when at least one flag is 1. A unicast address never sets hit_mcast.
- R9: dec_valid and the verdict appear in the cycle after the sixth address byte is taken. They then hold unchanged while further bytes arrive, until the next start of frame. Bytes received before any start of frame produce no decision.
- R10: A byte taken with sof=1 clears dec_valid, accept and the flags in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | A destination byte is present this cycle |
| sof | input | 1 | Marks the byte as the first of a frame (qualified by byte_valid) |
| byte_data | input | 8 | Received byte |
| rx_cfg | input | 4 | bit0 pass all, bit1 station match, bit2 multicast hash, bit3 broadcast |
| station_addr | input | 48 | Station address; bits 7:0 are the first byte on the wire |
| hash_wr | input | 1 | Write one word of the hash table |
| hash_sel | input | 1 | 0 selects table bits 31:0, 1 selects bits 63:32 |
| hash_wdata | input | 32 | Hash table word to write |
| dec_valid | output | 1 | Decision outputs are valid |
| accept | output | 1 | Frame passes the filter |
| hit_all | output | 1 | Pass-all rule fired |
| hit_phys | output | 1 | Station match rule fired |
| hit_mcast | output | 1 | Multicast hash rule fired |
| hit_bcast | output | 1 | Broadcast rule fired |

## Verification
The assertions assume the following about the inputs:
- sof is only meaningful when byte_valid is 1.
- Configuration, station address and hash table are stable while a frame's six address bytes are arriving.
- The decision is compared only after a start of frame.

The stimulus writes the table and changes the configuration only between frames. Every frame opens with a strobed first byte. Random gaps are placed only after the sixth byte, where the filter must ignore traffic. The addresses are a mix of random unicast and multicast addresses, exact copies of the station address, and broadcast. The table bit the CRC selects is set or cleared deliberately, so that both outcomes of the hash rule are exercised.

// File: rtl/rx_dst_filter_pkg.sv
package rx_dst_filter_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int ADDR_W     = ADDR_BYTES * 8;
    localparam int CRC_W      = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_INIT = '1;
    localparam int HASH_IDX_W = 6;
    localparam int HASH_BITS  = 1 << HASH_IDX_W;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        logic bcast;
        logic mcast;
        logic phys;
        logic all;
    } rx_cfg_t;

    typedef struct packed {
        logic all;
        logic phys;
        logic mcast;
        logic bcast;
    } hit_t;

    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0] crc_in,
        input logic [7:0]       data
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            fb = c[CRC_W-1] ^ data[b];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction
endpackage

// File: rtl/dst_collect.sv
module dst_collect
    import rx_dst_filter_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic              sof,
    input  logic [7:0]        byte_data,
    output logic              last_byte,
    output logic [ADDR_W-1:0] addr_next,
    output logic [CRC_W-1:0]  crc_next
);
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CRC_W-1:0]  crc_q;
    logic              take;

    assign take      = byte_valid && (sof || cnt_q < CNT_W'(ADDR_BYTES));
    assign last_byte = byte_valid && !sof && cnt_q == CNT_W'(ADDR_BYTES - 1);

    always_comb begin
        addr_next = addr_q;
        crc_next  = crc_q;
        if (sof) begin
            addr_next         = '0;
            addr_next[7:0]    = byte_data;
            crc_next          = crc_step_byte(CRC_INIT, byte_data);
        end else begin
            addr_next[8*cnt_q +: 8] = byte_data;
            crc_next                = crc_step_byte(crc_q, byte_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= CNT_W'(ADDR_BYTES);
            addr_q <= '0;
            crc_q  <= CRC_INIT;
        end else if (take) begin
            cnt_q  <= sof ? CNT_W'(1) : cnt_q + CNT_W'(1);
            addr_q <= addr_next;
            crc_q  <= crc_next;
        end
    end

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(ADDR_BYTES));
endmodule

// File: rtl/mc_hash_table.sv
module mc_hash_table
    import rx_dst_filter_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [SEL_W-1:0]     sel,
    input  logic [WORD_W-1:0]    wdata,
    input  logic [HASH_IDX_W-1:0] idx,
    output logic                 bit_out
);
    localparam int NWORDS = HASH_BITS / WORD_W;
    localparam int SEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    logic [HASH_BITS-1:0] table_q;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                table_q[w*WORD_W +: WORD_W] <= '0;
            end else if (wr && sel == SEL_W'(w)) begin
                table_q[w*WORD_W +: WORD_W] <= wdata;
            end
        end
    end

    assign bit_out = table_q[idx];
endmodule

// File: rtl/accept_decide.sv
module accept_decide
    import rx_dst_filter_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              last_byte,
    input  logic [ADDR_W-1:0] addr,
    input  logic              table_bit,
    input  logic [ADDR_W-1:0] station,
    input  rx_cfg_t           cfg,
    output logic              dec_valid,
    output hit_t              hits
);
    logic is_bcast, is_mcast, is_phys;
    hit_t hit_d;

    assign is_bcast = &addr;
    assign is_mcast = addr[0] && !is_bcast;
    assign is_phys  = addr == station;

    always_comb begin
        hit_d.all   = cfg.all;
        hit_d.phys  = cfg.phys && is_phys;
        hit_d.bcast = cfg.bcast && is_bcast;
        hit_d.mcast = cfg.mcast && is_mcast && table_bit;
    end

    always_ff @(posedge clk) begin
        if (rst || frame_start) begin
            dec_valid <= 1'b0;
            hits      <= '0;
        end else if (last_byte) begin
            dec_valid <= 1'b1;
            hits      <= hit_d;
        end
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        dec_valid && !frame_start |=> dec_valid && $stable(hits));
    p_sof_clear_r10: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !dec_valid && hits == '0);
    p_bcast_excl_r7: assert property (@(posedge clk) disable iff (rst)
        hits.mcast |-> !hits.bcast);
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> hits == '0);
endmodule

// File: rtl/rx_dst_filter.sv
module rx_dst_filter
    import rx_dst_filter_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        byte_valid,
    input  logic        sof,
    input  logic [7:0]  byte_data,
    input  logic [3:0]  rx_cfg,
    input  logic [47:0] station_addr,
    input  logic        hash_wr,
    input  logic        hash_sel,
    input  logic [31:0] hash_wdata,
    output logic        dec_valid,
    output logic        accept,
    output logic        hit_all,
    output logic        hit_phys,
    output logic        hit_mcast,
    output logic        hit_bcast
);
    logic              last_byte;
    logic [ADDR_W-1:0] addr_next;
    logic [CRC_W-1:0]  crc_next;
    logic              table_bit;
    hit_t              hits;

    dst_collect u_collect (
        .clk        (clk),
        .rst        (rst),
        .byte_valid (byte_valid),
        .sof        (sof),
        .byte_data  (byte_data),
        .last_byte  (last_byte),
        .addr_next  (addr_next),
        .crc_next   (crc_next)
    );

    mc_hash_table #(.WORD_W(32)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr      (hash_wr),
        .sel     (hash_sel),
        .wdata   (hash_wdata),
        .idx     (crc_next[CRC_W-1 -: HASH_IDX_W]),
        .bit_out (table_bit)
    );

    accept_decide u_decide (
        .clk         (clk),
        .rst         (rst),
        .frame_start (byte_valid && sof),
        .last_byte   (last_byte),
        .addr        (addr_next),
        .table_bit   (table_bit),
        .station     (station_addr),
        .cfg         (rx_cfg_t'(rx_cfg)),
        .dec_valid   (dec_valid),
        .hits        (hits)
    );

    assign hit_all   = hits.all;
    assign hit_phys  = hits.phys;
    assign hit_mcast = hits.mcast;
    assign hit_bcast = hits.bcast;
    assign accept    = |hits;

    p_valid_after_last_r9: assert property (@(posedge clk) disable iff (rst)
        last_byte |=> dec_valid);
    p_reject_when_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !accept);
endmodule

// File: tb/rx_dst_filter_test.sv
module rx_dst_filter_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        byte_valid, sof, hash_wr, hash_sel;
    logic [7:0]  byte_data;
    logic [3:0]  rx_cfg;
    logic [47:0] station_addr;
    logic [31:0] hash_wdata;
    logic        dec_valid, accept, hit_all, hit_phys, hit_mcast, hit_bcast;

    int n_checks = 0;
    int n_fail   = 0;
    logic [63:0] tbl_model;

    always #2.5 clk = ~clk;

    rx_dst_filter uut (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .sof(sof),
        .byte_data(byte_data), .rx_cfg(rx_cfg), .station_addr(station_addr),
        .hash_wr(hash_wr), .hash_sel(hash_sel), .hash_wdata(hash_wdata),
        .dec_valid(dec_valid), .accept(accept), .hit_all(hit_all),
        .hit_phys(hit_phys), .hit_mcast(hit_mcast), .hit_bcast(hit_bcast)
    );

    function automatic logic [5:0] hash_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = c[31] ^ a[i];
            c = c << 1;
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c[31:26];
    endfunction

    // {valid, accept, all, phys, mcast, bcast}
    function automatic logic [5:0] expect_out(input logic [47:0] a, input logic [3:0] cfg);
        logic b = (a == 48'hFFFF_FFFF_FFFF);
        logic e_all = cfg[0];
        logic e_phys = cfg[1] && (a == station_addr);
        logic e_mc = cfg[2] && a[0] && !b && tbl_model[hash_idx(a)];
        logic e_bc = cfg[3] && b;
        return {1'b1, e_all | e_phys | e_mc | e_bc, e_all, e_phys, e_mc, e_bc};
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs {valid,acc,all,phys,mc,bc} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [5:0] outs();
        return {dec_valid, accept, hit_all, hit_phys, hit_mcast, hit_bcast};
    endfunction

    task automatic write_tbl(input logic sel, input logic [31:0] d);
        @(negedge clk);
        hash_wr = 1'b1; hash_sel = sel; hash_wdata = d;
        @(negedge clk);
        hash_wr = 1'b0;
        if (sel) tbl_model[63:32] = d; else tbl_model[31:0] = d;
    endtask

    task automatic set_tbl_bit(input logic [5:0] idx, input logic v);
        logic [63:0] t = tbl_model;
        t[idx] = v;
        if (idx >= 32) write_tbl(1'b1, t[63:32]); else write_tbl(1'b0, t[31:0]);
    endtask

    task automatic send_frame(input logic [47:0] a, input int extra, input string req);
        logic [5:0] e;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 1) check("R10", outs(), 6'b0);
            byte_valid = 1'b1; sof = (i == 0); byte_data = a[8*i +: 8];
        end
        @(negedge clk);
        byte_valid = 1'b0; sof = 1'b0;
        e = expect_out(a, rx_cfg);
        check(req, outs(), e);
        for (int k = 0; k < extra; k++) begin
            @(negedge clk);
            byte_valid = $urandom_range(0, 1); byte_data = 8'($urandom);
        end
        @(negedge clk);
        byte_valid = 1'b0;
        @(negedge clk);
        if (extra > 0) check("R9", outs(), e);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; byte_valid = 0; sof = 0; byte_data = 0; rx_cfg = 0;
        hash_wr = 0; hash_sel = 0; hash_wdata = 0; tbl_model = '0;
        station_addr = 48'h5544_3322_1100;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", outs(), 6'b0);

        // R9: bytes before any sof give no decision
        rx_cfg = 4'b0001;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); byte_valid = 1'b1; byte_data = 8'(i);
        end
        @(negedge clk); byte_valid = 1'b0;
        @(negedge clk);
        check("R9", outs(), 6'b0);

        // R4 pass all
        send_frame(48'h0123_4567_89AA, 3, "R4");
        // R5 station match, and disabled (R8)
        rx_cfg = 4'b0010; send_frame(station_addr, 2, "R5");
        rx_cfg = 4'b1101; rx_cfg[0] = 0; send_frame(station_addr, 0, "R8");
        // R6 broadcast
        rx_cfg = 4'b1000; send_frame(48'hFFFF_FFFF_FFFF, 2, "R6");
        // R7 broadcast with its table bit set, hash enabled
        set_tbl_bit(hash_idx(48'hFFFF_FFFF_FFFF), 1'b1);
        rx_cfg = 4'b0100; send_frame(48'hFFFF_FFFF_FFFF, 0, "R7");
        rx_cfg = 4'b1100; send_frame(48'hFFFF_FFFF_FFFF, 0, "R7");
        // R2 multicast hit and miss; R3 both halves
        begin
            logic [47:0] m = 48'h0000_5E00_0001 | 48'h1;
            set_tbl_bit(hash_idx(m), 1'b1);
            rx_cfg = 4'b0100; send_frame(m, 1, "R2");
            set_tbl_bit(hash_idx(m), 1'b0);
            send_frame(m, 0, "R2");
        end
        write_tbl(1'b0, 32'h0); write_tbl(1'b1, 32'hFFFF_FFFF);
        for (int i = 0; i < 6; i++) begin
            logic [47:0] a = {$urandom, $urandom} | 48'h1;
            if (a == 48'hFFFF_FFFF_FFFF) a[47] = 1'b0;
            send_frame(a, 0, "R3");
        end
        write_tbl(1'b0, 32'hFFFF_FFFF); write_tbl(1'b1, 32'h0);
        for (int i = 0; i < 6; i++) begin
            logic [47:0] a = {$urandom, $urandom} | 48'h1;
            if (a == 48'hFFFF_FFFF_FFFF) a[47] = 1'b0;
            send_frame(a, 0, "R3");
        end
        // R8 unicast with all table bits set never hits multicast
        write_tbl(1'b0, 32'hFFFF_FFFF); write_tbl(1'b1, 32'hFFFF_FFFF);
        rx_cfg = 4'b1110;
        send_frame(48'h1234_5678_9ABC, 0, "R8");

        // Random mix
        for (int n = 0; n < 60; n++) begin
            logic [47:0] a;
            int kind = $urandom_range(0, 3);
            write_tbl(1'b0, $urandom); write_tbl(1'b1, $urandom);
            rx_cfg = 4'($urandom);
            case (kind)
                0: a = station_addr;
                1: a = 48'hFFFF_FFFF_FFFF;
                default: a = {$urandom, $urandom};
            endcase
            send_frame(a, $urandom_range(0, 4), "R2");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule